// File: doc/BRIEF.md
# PWM Event Flag, Interrupt and Converter Trigger Unit

This block sits beside a multi-channel PWM time base and turns its per-channel event strobes (counter at zero, counter at period, compare match while counting up, compare match while counting down, and counter wrap) into sticky status flags. Software enables each flag kind per channel towards a single interrupt line and clears any flag by writing a 1 to its clear bit.

Channels are grouped in pairs (even channel 2p, odd channel 2p+1). Each pair owns a 4-bit selection code that picks which event generates a one-clock trigger pulse for an analog-to-digital converter, plus an enable and a sticky trigger flag with its own write-1 clear. Counter generation and waveform shaping live outside this block.

Top module: `pwm_evt_irq_unit`

## Requirements
- R1: While reset is asserted every flag, every trigger pulse and the interrupt line are 0.
- R2: A strobe on `ev_zero`, `ev_prd`, `ev_cmpu` or `ev_cmpd` for channel c sets the matching flag bit c at the next rising clock edge, whatever the enables are, and the flag stays set until cleared.
- R3: A 1 on a clear bit clears the matching flag at the next edge; flags whose clear bit is 0 keep their value.
- R4: When a set strobe and a clear bit hit the same flag in the same cycle, the flag ends up set.
- R5: `irq` is 1 exactly when some channel has a zero, period, compare-up or compare-down flag set together with its enable; it follows the flags and enables without delay.
- R6: For pair p the code is `trig_sel[4p+3:4p]`; codes 0, 1, 2, 3, 4 fire on the even channel's zero, period, zero-or-period, compare-up and compare-down strobe respectively.
- R7: Codes 8 and 9 fire on the odd channel's compare-up and compare-down strobe respectively.
- R8: Codes 5 to 7 and 10 to 15, and any code while `trig_en[p]` is 0, produce no pulse and leave the trigger flag untouched.
- R9: A firing condition in cycle n gives `adc_trig[p]` high for the cycle after the edge ending cycle n, and sets `flg_trig[p]` at that same edge; `clr_trig[p]` clears it with set winning.
- R10: `ev_wrap` sets a per-channel wrap flag cleared by `clr_wrap`; this flag never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_zero | input | NCH | Counter-at-zero strobes |
| ev_prd | input | NCH | Counter-at-period strobes |
| ev_cmpu | input | NCH | Compare match while counting up |
| ev_cmpd | input | NCH | Compare match while counting down |
| ev_wrap | input | NCH | Counter wrap strobes |
| ien_zero | input | NCH | Interrupt enables for zero flags |
| ien_prd | input | NCH | Interrupt enables for period flags |
| ien_cmpu | input | NCH | Interrupt enables for compare-up flags |
| ien_cmpd | input | NCH | Interrupt enables for compare-down flags |
| clr_zero | input | NCH | Write-1 clears, zero flags |
| clr_prd | input | NCH | Write-1 clears, period flags |
| clr_cmpu | input | NCH | Write-1 clears, compare-up flags |
| clr_cmpd | input | NCH | Write-1 clears, compare-down flags |
| clr_wrap | input | NCH | Write-1 clears, wrap flags |
| trig_en | input | NCH/2 | Trigger enable per pair |
| trig_sel | input | 2*NCH | 4-bit trigger code per pair |
| clr_trig | input | NCH/2 | Write-1 clears, trigger flags |
| flg_zero | output | NCH | Zero flags |
| flg_prd | output | NCH | Period flags |
| flg_cmpu | output | NCH | Compare-up flags |
| flg_cmpd | output | NCH | Compare-down flags |
| flg_wrap | output | NCH | Wrap flags |
| flg_trig | output | NCH/2 | Trigger flags |
| adc_trig | output | NCH/2 | One-clock converter trigger pulses |
| irq | output | 1 | Combined interrupt |

## Verification
Every flag and trigger pulse is due exactly one rising edge after the cycle holding its strobe or clear, while `irq` is due in the same cycle as the flags and enables it combines. The bench drives inputs on the falling edge, advances its model over one rising edge, and compares all outputs on the following falling edge, before any input changes, so enables seen by `irq` are the ones the model used. Random stimulus covers all sixteen codes and overlapping set and clear, and directed steps pin the set-wins case, the odd-channel codes, an unused code and the wrap flag's isolation from `irq`.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    TRG_EVN_ZERO   = 4'd0,
    TRG_EVN_PRD    = 4'd1,
    TRG_EVN_ZORP   = 4'd2,
    TRG_EVN_CMPU   = 4'd3,
    TRG_EVN_CMPD   = 4'd4,
    TRG_ODD_CMPU   = 4'd8,
    TRG_ODD_CMPD   = 4'd9
  } trig_code_e;
endpackage

// File: rtl/pwm_evt_flags.sv
module pwm_evt_flags #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;
  logic         upd_en;

  // set dominates a simultaneous clear
  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
    upd_en  = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pwm_evt_trig_pair.sv
module pwm_evt_trig_pair
  import pwm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] sel_i,
  input  logic              evn_zero_i,
  input  logic              evn_prd_i,
  input  logic              evn_cmpu_i,
  input  logic              evn_cmpd_i,
  input  logic              odd_cmpu_i,
  input  logic              odd_cmpd_i,
  output logic              fire_o,
  output logic              pulse_o
);
  logic hit;
  logic pulse_q;

  always_comb begin
    case (sel_i)
      TRG_EVN_ZERO: hit = evn_zero_i;
      TRG_EVN_PRD:  hit = evn_prd_i;
      TRG_EVN_ZORP: hit = evn_zero_i | evn_prd_i;
      TRG_EVN_CMPU: hit = evn_cmpu_i;
      TRG_EVN_CMPD: hit = evn_cmpd_i;
      TRG_ODD_CMPU: hit = odd_cmpu_i;
      TRG_ODD_CMPD: hit = odd_cmpd_i;
      default:      hit = 1'b0;
    endcase
    fire_o = en_i & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_o;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/pwm_evt_irq_unit.sv
module pwm_evt_irq_unit
  import pwm_evt_pkg::*;
#(
  parameter int unsigned NCH = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            ev_zero,
  input  logic [NCH-1:0]            ev_prd,
  input  logic [NCH-1:0]            ev_cmpu,
  input  logic [NCH-1:0]            ev_cmpd,
  input  logic [NCH-1:0]            ev_wrap,
  input  logic [NCH-1:0]            ien_zero,
  input  logic [NCH-1:0]            ien_prd,
  input  logic [NCH-1:0]            ien_cmpu,
  input  logic [NCH-1:0]            ien_cmpd,
  input  logic [NCH-1:0]            clr_zero,
  input  logic [NCH-1:0]            clr_prd,
  input  logic [NCH-1:0]            clr_cmpu,
  input  logic [NCH-1:0]            clr_cmpd,
  input  logic [NCH-1:0]            clr_wrap,
  input  logic [NCH/2-1:0]          trig_en,
  input  logic [NCH/2*CODE_W-1:0]   trig_sel,
  input  logic [NCH/2-1:0]          clr_trig,
  output logic [NCH-1:0]            flg_zero,
  output logic [NCH-1:0]            flg_prd,
  output logic [NCH-1:0]            flg_cmpu,
  output logic [NCH-1:0]            flg_cmpd,
  output logic [NCH-1:0]            flg_wrap,
  output logic [NCH/2-1:0]          flg_trig,
  output logic [NCH/2-1:0]          adc_trig,
  output logic                      irq
);
  localparam int unsigned NPAIR = NCH / 2;

  logic [NPAIR-1:0] trig_fire;

  pwm_evt_flags #(.W(NCH)) u_zero (
    .clk(clk), .rst_n(rst_n), .set_i(ev_zero), .clr_i(clr_zero), .flags_o(flg_zero));
  pwm_evt_flags #(.W(NCH)) u_prd (
    .clk(clk), .rst_n(rst_n), .set_i(ev_prd), .clr_i(clr_prd), .flags_o(flg_prd));
  pwm_evt_flags #(.W(NCH)) u_cmpu (
    .clk(clk), .rst_n(rst_n), .set_i(ev_cmpu), .clr_i(clr_cmpu), .flags_o(flg_cmpu));
  pwm_evt_flags #(.W(NCH)) u_cmpd (
    .clk(clk), .rst_n(rst_n), .set_i(ev_cmpd), .clr_i(clr_cmpd), .flags_o(flg_cmpd));
  pwm_evt_flags #(.W(NCH)) u_wrap (
    .clk(clk), .rst_n(rst_n), .set_i(ev_wrap), .clr_i(clr_wrap), .flags_o(flg_wrap));

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_evt_trig_pair u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (trig_en[p]),
      .sel_i      (trig_sel[p*CODE_W +: CODE_W]),
      .evn_zero_i (ev_zero[2*p]),
      .evn_prd_i  (ev_prd[2*p]),
      .evn_cmpu_i (ev_cmpu[2*p]),
      .evn_cmpd_i (ev_cmpd[2*p]),
      .odd_cmpu_i (ev_cmpu[2*p+1]),
      .odd_cmpd_i (ev_cmpd[2*p+1]),
      .fire_o     (trig_fire[p]),
      .pulse_o    (adc_trig[p])
    );
  end

  pwm_evt_flags #(.W(NPAIR)) u_trig (
    .clk(clk), .rst_n(rst_n), .set_i(trig_fire), .clr_i(clr_trig), .flags_o(flg_trig));

  always_comb begin
    irq = |((flg_zero & ien_zero) | (flg_prd & ien_prd) |
            (flg_cmpu & ien_cmpu) | (flg_cmpd & ien_cmpd));
  end
endmodule

// File: rtl/pwm_evt_irq_unit_chk.sv
module pwm_evt_irq_unit_chk #(
  parameter int unsigned NCH = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   ev_zero,
  input logic [NCH-1:0]   ev_cmpd,
  input logic [NCH-1:0]   clr_zero,
  input logic [NCH-1:0]   flg_zero,
  input logic [NCH-1:0]   flg_prd,
  input logic [NCH-1:0]   flg_cmpu,
  input logic [NCH-1:0]   flg_cmpd,
  input logic [NCH/2-1:0] trig_en,
  input logic [NCH/2-1:0] flg_trig,
  input logic [NCH/2-1:0] adc_trig,
  input logic             irq
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2: a zero strobe leaves its flag set one edge later
  assert_zero_set_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(ev_zero) & ~flg_zero) == '0));

  // R4: compare-down strobe wins over anything else in the same cycle
  assert_cmpd_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(ev_cmpd) & ~flg_cmpd) == '0));

  // R3: a clear without a strobe empties the flag
  assert_zero_clear_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ((($past(clr_zero) & ~$past(ev_zero)) & flg_zero) == '0));

  // R5: interrupt needs at least one pending flag
  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    irq |-> (|(flg_zero | flg_prd | flg_cmpu | flg_cmpd)));

  // R8: no pulse from a pair whose trigger was disabled
  assert_pulse_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ((adc_trig & ~$past(trig_en)) == '0));

  // R9: every pulse comes with its trigger flag
  assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ((adc_trig & ~flg_trig) == '0));
endmodule

bind pwm_evt_irq_unit pwm_evt_irq_unit_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_zero(ev_zero), .ev_cmpd(ev_cmpd),
  .clr_zero(clr_zero), .flg_zero(flg_zero), .flg_prd(flg_prd),
  .flg_cmpu(flg_cmpu), .flg_cmpd(flg_cmpd), .trig_en(trig_en),
  .flg_trig(flg_trig), .adc_trig(adc_trig), .irq(irq));

// File: tb/pwm_evt_irq_unit_tb.sv
module pwm_evt_irq_unit_tb;
  localparam int unsigned NCH   = 6;
  localparam int unsigned NPAIR = NCH / 2;
  localparam time CLK_PERIOD    = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] ev_zero, ev_prd, ev_cmpu, ev_cmpd, ev_wrap;
  logic [NCH-1:0] ien_zero, ien_prd, ien_cmpu, ien_cmpd;
  logic [NCH-1:0] clr_zero, clr_prd, clr_cmpu, clr_cmpd, clr_wrap;
  logic [NPAIR-1:0] trig_en, clr_trig;
  logic [NPAIR*4-1:0] trig_sel;
  logic [NCH-1:0] flg_zero, flg_prd, flg_cmpu, flg_cmpd, flg_wrap;
  logic [NPAIR-1:0] flg_trig, adc_trig;
  logic irq;

  logic [NCH-1:0] m_zero, m_prd, m_cmpu, m_cmpd, m_wrap;
  logic [NPAIR-1:0] m_tflg, m_pulse;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_evt_irq_unit #(.NCH(NCH)) u_dut (.*);

  function automatic logic trig_hit(input logic [3:0] code, input int p);
    case (code)
      4'd0: return ev_zero[2*p];
      4'd1: return ev_prd[2*p];
      4'd2: return ev_zero[2*p] | ev_prd[2*p];
      4'd3: return ev_cmpu[2*p];
      4'd4: return ev_cmpd[2*p];
      4'd8: return ev_cmpu[2*p+1];
      4'd9: return ev_cmpd[2*p+1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |((m_zero & ien_zero) | (m_prd & ien_prd) | (m_cmpu & ien_cmpu) | (m_cmpd & ien_cmpd));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    ev_zero = '0; ev_prd = '0; ev_cmpu = '0; ev_cmpd = '0; ev_wrap = '0;
    clr_zero = '0; clr_prd = '0; clr_cmpu = '0; clr_cmpd = '0; clr_wrap = '0;
    clr_trig = '0;
  endtask

  task automatic compare_all();
    check(flg_zero === m_zero, "R2/R3 zero flags", 32'(flg_zero), 32'(m_zero));
    check(flg_prd  === m_prd,  "R2/R3 period flags", 32'(flg_prd), 32'(m_prd));
    check(flg_cmpu === m_cmpu, "R2/R4 cmp-up flags", 32'(flg_cmpu), 32'(m_cmpu));
    check(flg_cmpd === m_cmpd, "R2/R4 cmp-down flags", 32'(flg_cmpd), 32'(m_cmpd));
    check(flg_wrap === m_wrap, "R10 wrap flags", 32'(flg_wrap), 32'(m_wrap));
    check(flg_trig === m_tflg, "R9 trigger flags", 32'(flg_trig), 32'(m_tflg));
    check(adc_trig === m_pulse, "R6/R7/R8 trigger pulses", 32'(adc_trig), 32'(m_pulse));
    check(irq === exp_irq(), "R5 irq", 32'(irq), 32'(exp_irq()));
  endtask

  // inputs are already set; advance model over one edge, compare at falling edge
  task automatic tick();
    logic [NPAIR-1:0] fire;
    for (int p = 0; p < NPAIR; p++) fire[p] = trig_en[p] & trig_hit(trig_sel[4*p +: 4], p);
    @(posedge clk);
    m_zero  = (m_zero & ~clr_zero) | ev_zero;
    m_prd   = (m_prd  & ~clr_prd)  | ev_prd;
    m_cmpu  = (m_cmpu & ~clr_cmpu) | ev_cmpu;
    m_cmpd  = (m_cmpd & ~clr_cmpd) | ev_cmpd;
    m_wrap  = (m_wrap & ~clr_wrap) | ev_wrap;
    m_tflg  = (m_tflg & ~clr_trig) | fire;
    m_pulse = fire;
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [NCH-1:0] sparse();
    return NCH'($urandom) & NCH'($urandom);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    idle_inputs();
    ien_zero = '1; ien_prd = '1; ien_cmpu = '1; ien_cmpd = '1;
    trig_en = '1; trig_sel = '0;
    ev_zero = '1;
    m_zero = '0; m_prd = '0; m_cmpu = '0; m_cmpd = '0; m_wrap = '0;
    m_tflg = '0; m_pulse = '0;
    repeat (3) @(negedge clk);
    // R1: reset holds everything low even with strobes present
    check(flg_zero === '0 && flg_trig === '0, "R1 flags in reset", 32'(flg_zero), 32'h0);
    check(adc_trig === '0, "R1 pulses in reset", 32'(adc_trig), 32'h0);
    check(irq === 1'b0, "R1 irq in reset", 32'(irq), 32'h0);
    idle_inputs();
    rst_n = 1'b1;
    @(negedge clk);

    // R4: set and clear on the same flag
    ev_zero = 6'b000001;
    tick();
    idle_inputs();
    ev_zero = 6'b000001; clr_zero = 6'b000011;
    tick();
    check(flg_zero[0] === 1'b1, "R4 set beats clear", 32'(flg_zero[0]), 32'h1);
    idle_inputs();
    clr_zero = 6'b000001;
    tick();
    check(flg_zero[0] === 1'b0, "R3 write-1 clear", 32'(flg_zero[0]), 32'h0);

    // R7: odd channel compare codes on pair 1
    idle_inputs();
    trig_sel = {4'd0, 4'd8, 4'd0}; trig_en = 3'b010;
    ev_cmpu = 6'b001000;
    tick();
    check(adc_trig === 3'b010, "R7 odd cmp-up code 8", 32'(adc_trig), 32'h2);
    idle_inputs();
    trig_sel = {4'd0, 4'd9, 4'd0};
    ev_cmpd = 6'b001000;
    tick();
    check(adc_trig === 3'b010, "R7 odd cmp-down code 9", 32'(adc_trig), 32'h2);
    idle_inputs();
    tick();
    check(adc_trig === 3'b000, "R9 pulse lasts one clock", 32'(adc_trig), 32'h0);

    // R8: unused code with every strobe active
    idle_inputs();
    clr_trig = '1;
    tick();
    idle_inputs();
    trig_en = '1; trig_sel = {4'd5, 4'd12, 4'd7};
    ev_zero = '1; ev_prd = '1; ev_cmpu = '1; ev_cmpd = '1;
    tick();
    check(adc_trig === '0 && flg_trig === '0, "R8 unused codes", 32'(adc_trig), 32'h0);

    // R6: code 2 on pair 2 fires on period alone
    idle_inputs();
    trig_sel = {4'd2, 4'd0, 4'd0}; trig_en = 3'b100;
    ev_prd = 6'b010000;
    tick();
    check(adc_trig === 3'b100, "R6 zero-or-period code 2", 32'(adc_trig), 32'h4);

    // R10: wrap flag never raises irq
    idle_inputs();
    clr_zero = '1; clr_prd = '1; clr_cmpu = '1; clr_cmpd = '1;
    tick();
    idle_inputs();
    ev_wrap = '1;
    tick();
    check(flg_wrap === '1 && irq === 1'b0, "R10 wrap isolated from irq", 32'(irq), 32'h0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      ev_zero = sparse(); ev_prd = sparse(); ev_cmpu = sparse();
      ev_cmpd = sparse(); ev_wrap = sparse();
      clr_zero = sparse(); clr_prd = sparse(); clr_cmpu = sparse();
      clr_cmpd = sparse(); clr_wrap = sparse();
      clr_trig = NPAIR'($urandom) & NPAIR'($urandom);
      ien_zero = sparse(); ien_prd = sparse(); ien_cmpu = sparse(); ien_cmpd = sparse();
      trig_en = NPAIR'($urandom);
      trig_sel = (NPAIR*4)'($urandom);
      tick();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule